// File: doc/BRIEF.md
# Multi-Channel Analog Watchdog Bank

This block watches the stream of conversion results that a converter sequencer produces. It holds a bank of watchdog units. Each unit is programmed with a channel to monitor, a floor value, a ceiling value and an enable. The floor and ceiling together define the window that the unit accepts. When a valid result arrives for the unit's channel and lies below the floor or above the ceiling, the unit latches a matching violation flag. A flag then stays set until software clears it with a write-one-to-clear pulse.

All units look at the same result in parallel and work independently of one another. Several units may therefore watch the same channel with different windows. The below-window and above-window flags are separate outputs. A single interrupt line merges the flags of every enabled unit. Decoding of the programming registers and sequencing of the converter belong to neighbouring logic. This block receives its configuration as flat vectors. The fields of unit i sit in slice `[i*W +: W]` of each vector.

Top module: `awd_bank`

## Requirements
- R1: After reset, every flag_lo and flag_hi bit is 0 and irq is 0.
- R2: If res_valid is 1, cfg_en[i] is 1, res_chan equals the channel field of unit i, and res_value is less than the unit's floor, then flag_lo[i] reads 1 from the next clock edge on.
- R3: If res_valid is 1, cfg_en[i] is 1, res_chan equals the channel field of unit i, and res_value is greater than the unit's ceiling, then flag_hi[i] reads 1 from the next clock edge on.
- R4: Results and thresholds are RES_W-bit unsigned numbers (10 bits by default). A result equal to the floor or to the ceiling lies inside the window and sets no flag.
- R5: A cycle with res_valid at 0, or with res_chan different from the channel field of unit i, sets no flag of unit i.
- R6: While cfg_en[i] is 0, no result sets flag_lo[i] or flag_hi[i].
- R7: Once set, a flag keeps its value on every cycle in which its clear bit is 0.
- R8: A 1 on clr_lo[i] clears flag_lo[i] at the next edge, and a 1 on clr_hi[i] clears flag_hi[i] at the next edge. Clear bits that are 0 have no effect.
- R9: If a violation and the clear bit for the same flag arrive in the same cycle, the flag reads 1 after the edge.
- R10: irq is the OR, over all units, of (flag_lo[i] OR flag_hi[i]) AND cfg_en[i]. It follows cfg_en combinationally, so disabling a unit masks any flag it holds.
- R11: Each unit evaluates every result on its own. Two units set to the same channel each apply their own window to the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Strobe: a conversion result is present this cycle |
| res_chan | input | CH_W | Channel number of the present result |
| res_value | input | RES_W | Unsigned conversion result |
| cfg_en | input | NUM_UNITS | Enable of each unit, bit i for unit i |
| cfg_chan | input | NUM_UNITS*CH_W | Monitored channel of each unit |
| cfg_lo | input | NUM_UNITS*RES_W | Floor (lower threshold) of each unit |
| cfg_hi | input | NUM_UNITS*RES_W | Ceiling (upper threshold) of each unit |
| clr_lo | input | NUM_UNITS | Write-one-to-clear pulses for the below-window flags |
| clr_hi | input | NUM_UNITS | Write-one-to-clear pulses for the above-window flags |
| flag_lo | output | NUM_UNITS | Sticky below-window violation flags |
| flag_hi | output | NUM_UNITS | Sticky above-window violation flags |
| irq | output | 1 | Merged interrupt of all enabled units' flags |

## Verification
The assertions assume that the configuration vectors are stable around the clock edge. They also assume that res_value and res_chan carry known values whenever res_valid is high, because the comparison results feed the flag registers directly. The stimulus drives every input only at the falling clock edge. It rewrites the configuration only on cycles in which it applies no result, so the value seen at a rising edge is always the value just set up. Random results are drawn from a small set of channels, so that matches, mismatches and shared-channel units all occur often. Random thresholds sometimes place the floor above the ceiling; in that case both flags may set on the same result.

// File: rtl/awd_pkg.sv
package awd_pkg;

   localparam int unsigned AWD_MAX_UNITS = 8;

   typedef struct packed {
      logic below;
      logic above;
   } awd_viol_t;

endpackage

// File: rtl/awd_window_cmp.sv
module awd_window_cmp
   import awd_pkg::*;
#(
   parameter int unsigned RES_W = 10,
   parameter int unsigned CH_W  = 6
) (
   input  logic             res_valid,
   input  logic [CH_W-1:0]  res_chan,
   input  logic [RES_W-1:0] res_value,
   input  logic             unit_en,
   input  logic [CH_W-1:0]  unit_chan,
   input  logic [RES_W-1:0] unit_lo,
   input  logic [RES_W-1:0] unit_hi,
   output awd_viol_t        viol
);

   logic hit;

   // A unit looks at a result only when it is enabled, the strobe is up
   // and the channel numbers agree.
   assign hit = res_valid & unit_en & (res_chan == unit_chan);

   // Both bounds belong to the window (inclusive compare).
   always_comb begin
      viol.below = hit & (res_value < unit_lo);
      viol.above = hit & (res_value > unit_hi);
   end

endmodule

// File: rtl/awd_flag_reg.sv
module awd_flag_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);

   // A new violation in the same cycle as a clear takes priority.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= set | (q & ~clr);
   end

   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !clr) |=> q);

   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !q);

   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> q);

endmodule

// File: rtl/awd_bank.sv
module awd_bank
   import awd_pkg::*;
#(
   parameter int unsigned NUM_UNITS = 4,
   parameter int unsigned RES_W     = 10,
   parameter int unsigned CH_W      = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       res_valid,
   input  logic [CH_W-1:0]            res_chan,
   input  logic [RES_W-1:0]           res_value,
   input  logic [NUM_UNITS-1:0]       cfg_en,
   input  logic [NUM_UNITS*CH_W-1:0]  cfg_chan,
   input  logic [NUM_UNITS*RES_W-1:0] cfg_lo,
   input  logic [NUM_UNITS*RES_W-1:0] cfg_hi,
   input  logic [NUM_UNITS-1:0]       clr_lo,
   input  logic [NUM_UNITS-1:0]       clr_hi,
   output logic [NUM_UNITS-1:0]       flag_lo,
   output logic [NUM_UNITS-1:0]       flag_hi,
   output logic                       irq
);

   localparam int unsigned FLAG_CNT = 2 * NUM_UNITS;

   // Elaboration-time parameter checks
   generate
      if (NUM_UNITS < 1 || NUM_UNITS > AWD_MAX_UNITS) begin : g_bad_units
         $error("awd_bank: NUM_UNITS out of range");
      end
      if (RES_W < 2 || RES_W > 16) begin : g_bad_resw
         $error("awd_bank: RES_W out of range");
      end
      if (CH_W < 1 || CH_W > 8) begin : g_bad_chw
         $error("awd_bank: CH_W out of range");
      end
   endgenerate

   logic [FLAG_CNT-1:0] gated_flags;

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      awd_viol_t viol;

      awd_window_cmp #(.RES_W(RES_W), .CH_W(CH_W)) u_cmp (
         .res_valid (res_valid),
         .res_chan  (res_chan),
         .res_value (res_value),
         .unit_en   (cfg_en[u]),
         .unit_chan (cfg_chan[u*CH_W +: CH_W]),
         .unit_lo   (cfg_lo[u*RES_W +: RES_W]),
         .unit_hi   (cfg_hi[u*RES_W +: RES_W]),
         .viol      (viol)
      );

      awd_flag_reg u_lo (
         .clk   (clk),
         .rst_n (rst_n),
         .set   (viol.below),
         .clr   (clr_lo[u]),
         .q     (flag_lo[u])
      );

      awd_flag_reg u_hi (
         .clk   (clk),
         .rst_n (rst_n),
         .set   (viol.above),
         .clr   (clr_hi[u]),
         .q     (flag_hi[u])
      );

      assign gated_flags[2*u]   = flag_lo[u] & cfg_en[u];
      assign gated_flags[2*u+1] = flag_hi[u] & cfg_en[u];

      // R6: a disabled unit raises nothing
      a_r6_disabled_lo: assert property (@(posedge clk) disable iff (!rst_n)
         (!cfg_en[u] && !flag_lo[u]) |=> !flag_lo[u]);
      a_r6_disabled_hi: assert property (@(posedge clk) disable iff (!rst_n)
         (!cfg_en[u] && !flag_hi[u]) |=> !flag_hi[u]);

      // R5: no strobe or another channel leaves the flags alone
      a_r5_no_match: assert property (@(posedge clk) disable iff (!rst_n)
         ((!res_valid || res_chan != cfg_chan[u*CH_W +: CH_W])
          && !flag_lo[u] && !flag_hi[u]) |=> (!flag_lo[u] && !flag_hi[u]));

      // R2: a result below the floor is latched
      a_r2_below_sets: assert property (@(posedge clk) disable iff (!rst_n)
         (res_valid && cfg_en[u] && res_chan == cfg_chan[u*CH_W +: CH_W]
          && res_value < cfg_lo[u*RES_W +: RES_W]) |=> flag_lo[u]);

      // R3: a result above the ceiling is latched
      a_r3_above_sets: assert property (@(posedge clk) disable iff (!rst_n)
         (res_valid && cfg_en[u] && res_chan == cfg_chan[u*CH_W +: CH_W]
          && res_value > cfg_hi[u*RES_W +: RES_W]) |=> flag_hi[u]);
   end

   assign irq = |gated_flags;

   // R1: nothing pending right after reset
   a_r1_reset_clear: assert property (@(posedge clk)
      $rose(rst_n) |-> (flag_lo == '0 && flag_hi == '0));

endmodule

// File: tb/awd_bank_tb.sv
`timescale 1ns/1ps
module awd_bank_tb;

   localparam int N  = 4;
   localparam int RW = 10;
   localparam int CW = 6;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            res_valid;
   logic [CW-1:0]   res_chan;
   logic [RW-1:0]   res_value;
   logic [N-1:0]    cfg_en;
   logic [N*CW-1:0] cfg_chan;
   logic [N*RW-1:0] cfg_lo;
   logic [N*RW-1:0] cfg_hi;
   logic [N-1:0]    clr_lo;
   logic [N-1:0]    clr_hi;
   logic [N-1:0]    flag_lo;
   logic [N-1:0]    flag_hi;
   logic            irq;

   logic [N-1:0]    m_lo, m_hi;
   int              n_vec = 0;
   int              n_bad = 0;
   int              cycles = 0;
   bit              done = 0;

   always #2 clk = ~clk;   // 250 MHz

   awd_bank #(.NUM_UNITS(N), .RES_W(RW), .CH_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
      .res_value(res_value), .cfg_en(cfg_en), .cfg_chan(cfg_chan),
      .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .clr_lo(clr_lo), .clr_hi(clr_hi),
      .flag_lo(flag_lo), .flag_hi(flag_hi), .irq(irq)
   );

   function automatic logic exp_irq(input logic [N-1:0] lo, input logic [N-1:0] hi,
                                    input logic [N-1:0] en);
      return |((lo | hi) & en);
   endfunction

   task automatic check(input string tag);
      logic ei;
      ei = exp_irq(m_lo, m_hi, cfg_en);
      n_vec++;
      if (flag_lo !== m_lo || flag_hi !== m_hi || irq !== ei) begin
         n_bad++;
         $display("FAIL %s: lo=%b hi=%b irq=%b expected lo=%b hi=%b irq=%b",
                  tag, flag_lo, flag_hi, irq, m_lo, m_hi, ei);
      end
   endtask

   task automatic set_unit(input int i, input logic en, input logic [CW-1:0] ch,
                           input logic [RW-1:0] lo, input logic [RW-1:0] hi);
      cfg_en[i]           = en;
      cfg_chan[i*CW +: CW] = ch;
      cfg_lo[i*RW +: RW]   = lo;
      cfg_hi[i*RW +: RW]   = hi;
   endtask

   // Drive at the falling edge, predict, then sample 1 ns after the rising edge.
   task automatic apply(input logic v, input logic [CW-1:0] ch, input logic [RW-1:0] val,
                        input logic [N-1:0] cl, input logic [N-1:0] chh, input string tag);
      @(negedge clk);
      res_valid = v; res_chan = ch; res_value = val; clr_lo = cl; clr_hi = chh;
      for (int i = 0; i < N; i++) begin
         logic hit;
         hit = v && cfg_en[i] && (ch == cfg_chan[i*CW +: CW]);
         m_lo[i] = (hit && val < cfg_lo[i*RW +: RW]) | (m_lo[i] & ~cl[i]);
         m_hi[i] = (hit && val > cfg_hi[i*RW +: RW]) | (m_hi[i] & ~chh[i]);
      end
      @(posedge clk);
      #1;
      check(tag);
   endtask

   // Configuration changes only on an idle cycle (no result applied).
   task automatic idle_cfg_sync;
      @(negedge clk);
      res_valid = 1'b0; clr_lo = '0; clr_hi = '0;
   endtask

   initial begin
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: timeout after %0d cycles, expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'd20240607));
      rst_n = 1'b0; res_valid = 0; res_chan = '0; res_value = '0;
      cfg_en = '0; cfg_chan = '0; cfg_lo = '0; cfg_hi = '0; clr_lo = '0; clr_hi = '0;
      m_lo = '0; m_hi = '0;
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset state");
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 after reset release");

      // Windows: unit0 ch5 [100,200], unit1 ch5 [150,300], unit2 ch9 [0,1023], unit3 ch9 disabled
      set_unit(0, 1, 6'd5, 10'd100, 10'd200);
      set_unit(1, 1, 6'd5, 10'd150, 10'd300);
      set_unit(2, 1, 6'd9, 10'd0,   10'd1023);
      set_unit(3, 0, 6'd9, 10'd400, 10'd500);

      apply(1, 6'd5, 10'd100, '0, '0, "R4 value equals floor");
      apply(1, 6'd5, 10'd200, '0, '0, "R4 value equals ceiling (unit0)");
      apply(1, 6'd5, 10'd99,  '0, '0, "R2 below floor, R11 both units");
      apply(0, 6'd5, 10'd500, '0, '0, "R5 no strobe");
      apply(1, 6'd7, 10'd1000,'0, '0, "R5 channel mismatch");
      apply(1, 6'd5, 10'd250, '0, '0, "R3 above unit0 ceiling, R11 inside unit1");
      apply(0, 6'd0, 10'd0,   '0, '0, "R7 flags hold while idle");
      apply(1, 6'd9, 10'd1023,'0, '0, "R6 disabled unit3 ignores, R4 full-scale bound");
      apply(1, 6'd9, 10'd0,   '0, '0, "R6 disabled unit3 ignores low value");
      apply(0, 6'd0, 10'd0, 4'b0001, 4'b0000, "R8 clear unit0 low flag only");
      apply(1, 6'd5, 10'd10, 4'b0010, 4'b0001, "R9 set wins over clear");
      idle_cfg_sync();
      cfg_en[1] = 1'b0; cfg_en[0] = 1'b0;
      #1;
      check("R10 irq masked by disable");
      cfg_en[0] = 1'b1;
      #1;
      check("R10 irq follows re-enable");
      apply(0, 6'd0, 10'd0, 4'b1111, 4'b1111, "R8 clear all flags");

      // Constrained random phase
      for (int blk = 0; blk < 60; blk++) begin
         idle_cfg_sync();
         for (int i = 0; i < N; i++) begin
            logic [RW-1:0] a, b;
            a = RW'($urandom);
            b = RW'($urandom);
            if (($urandom % 5) != 0 && a > b) begin
               logic [RW-1:0] t;
               t = a; a = b; b = t;
            end
            set_unit(i, ($urandom % 4) != 0, CW'($urandom % 4), a, b);
         end
         #1;
         check("R10 after reconfiguration");
         for (int k = 0; k < 40; k++) begin
            logic [N-1:0] cl, chh;
            logic [RW-1:0] val;
            cl  = N'(($urandom % 6 == 0) ? $urandom : 0);
            chh = N'(($urandom % 6 == 0) ? $urandom : 0);
            case ($urandom % 4)
               0: val = cfg_lo[((k % N))*RW +: RW];
               1: val = cfg_hi[((k % N))*RW +: RW];
               default: val = RW'($urandom);
            endcase
            apply(($urandom % 4) != 0, CW'($urandom % 5), val, cl, chh,
                  "R2/R3/R5/R6/R7/R8/R9/R11 random");
         end
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule